// File: doc/BRIEF.md
# Disk Sector Transfer Step Sequencer

This block runs one disk sector transfer as a fixed program of 32 control steps. There are two programs, one for reading and one for writing. Each 8-bit control word carries four action flags and a 4-bit index into a small parameter store. The indexed parameter is either a tag command, which goes to the drive's tag register, or a length, which loads a down-counter that sets how long the step lasts. The outputs are a tag-load strobe with its value, serializer load and read enables, an ECC-compute enable and a new-block indication. The serializer, the ECC generator and the drive sit outside this block.

Software fills the parameter store through a simple write port while the sequencer is idle. A start pulse then runs steps 0 to 31 and the block returns to idle. The read/write select is taken at start. After that it is taken again only on leaving a step whose new-block flag is set, so the program can switch between read and write only at a block boundary. The read-tag step does not count. It holds until the sync-detect input is seen.

Top module: `sector_sequencer`

## Requirements
- R1: After reset the block is idle: busy, step, tag_load, tag_value, sr_load, sr_read, ecc_en and new_block are all 0.
- R2: A start seen while idle makes busy 1 with step 0 on the next cycle. A start seen while busy has no effect.
- R3: Control word layout: bit 7 serializer enable, bit 6 ECC enable, bit 5 new-block, bit 4 tag step, bits 3:0 parameter index. Parameter entries: 0-3 block word counts, 4 read tag, 5 write tag, 6 init tag, 7 reset tag, 8/9 write preamble length (first/later block), 10/11 read wait length (first/later block), 12 ECC-plus-one length, 13 settle length, 14 minimum length.
- R4: A step without the tag flag loads the counter from its parameter P and lasts exactly P+1 cycles. The step number then rises by one.
- R5: A tag step other than the read tag lasts one cycle. tag_load is 1 only in the first cycle of any tag step, and tag_value then equals the indexed parameter. Otherwise tag_value is 0.
- R6: The read-tag step (tag flag, index 4) holds until sync_det is 1, then advances on that cycle's edge.
- R7: Each read block is 7 steps: wait (10 or 11); read tag; data (count index, ECC, serializer); ECC words (13, ECC, serializer); init tag with serializer; minimum (14) with serializer; minimum (14) with new-block.
- R8: Each write block is 7 steps: write tag; preamble (8 or 9); minimum (14) with ECC and serializer; data (count index, ECC, serializer); minimum (14) with ECC; ECC-plus-one (12); minimum (14) with new-block.
- R9: Step 0 is the init tag and step 1 is the settle length (13). Block b (0-3) occupies steps 2+7b to 8+7b and uses count index b. Only block 0 uses entries 8/10. Steps 30 and 31 both issue the reset tag with new-block.
- R10: The program select is sampled at start and at the end of a step whose new-block flag is set. A change of rd_sel at any other time has no effect.
- R11: After step 31 completes the block returns to idle with step 0.
- R12: A parameter write (prm_we) is stored while idle. It is ignored while busy, and writes to address 15 are dropped.
- R13: The serializer flag drives sr_read in the read program and sr_load in the write program, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sector program |
| rd_sel | input | 1 | Program select, 1 = read, 0 = write |
| sync_det | input | 1 | Sync pattern detected by the read path |
| prm_we | input | 1 | Parameter store write enable |
| prm_addr | input | 4 | Parameter store address |
| prm_wdata | input | 12 | Parameter store write data |
| busy | output | 1 | Program running |
| step | output | 5 | Current step number |
| tag_load | output | 1 | Tag register load strobe |
| tag_value | output | 12 | Tag command to load |
| sr_load | output | 1 | Serializer load enable (write) |
| sr_read | output | 1 | Serializer read enable (read) |
| ecc_en | output | 1 | ECC compute enable |
| new_block | output | 1 | New-block command |

## Verification
The step outputs are decoded combinationally from registered state. The cycle after a start edge shows step 0. Each later cycle shows the step the bench's model reaches by adding P+1 cycles per counted step, one per plain tag step, and the wait length plus one for the read tag. The bench drives inputs and compares at the falling edge. Its expected step advances exactly when the modelled duration runs out. The program-select value it uses for the next block is the rd_sel it drove during the final cycle of a new-block step. After step 31's last cycle, idle is expected at the very next compare.

// File: rtl/sectseq_pkg.sv
package sectseq_pkg;

  localparam int STEPS    = 32;
  localparam int STEP_W   = $clog2(STEPS);
  localparam int IDX_W    = 4;
  localparam int PRM_N    = 15;

  localparam logic [IDX_W-1:0] IX_TAG_RD   = 4'd4;
  localparam logic [IDX_W-1:0] IX_TAG_WR   = 4'd5;
  localparam logic [IDX_W-1:0] IX_TAG_INIT = 4'd6;
  localparam logic [IDX_W-1:0] IX_TAG_RST  = 4'd7;
  localparam logic [IDX_W-1:0] IX_WPRE_1ST = 4'd8;
  localparam logic [IDX_W-1:0] IX_WPRE_NXT = 4'd9;
  localparam logic [IDX_W-1:0] IX_RWAIT_1ST = 4'd10;
  localparam logic [IDX_W-1:0] IX_RWAIT_NXT = 4'd11;
  localparam logic [IDX_W-1:0] IX_ECC_P1   = 4'd12;
  localparam logic [IDX_W-1:0] IX_SETTLE   = 4'd13;
  localparam logic [IDX_W-1:0] IX_MIN      = 4'd14;

  typedef struct packed {
    logic             ser;
    logic             ecc;
    logic             nblk;
    logic             tag;
    logic [IDX_W-1:0] idx;
  } ctl_word_t;

  function automatic ctl_word_t mk(logic ser, logic ecc, logic nblk, logic tag,
                                   logic [IDX_W-1:0] idx);
    ctl_word_t w;
    w.ser = ser; w.ecc = ecc; w.nblk = nblk; w.tag = tag; w.idx = idx;
    return w;
  endfunction

  // Control word for a given program (rd=1 read) and step number.
  function automatic ctl_word_t prog_word(logic rd, logic [STEP_W-1:0] s);
    int unsigned rel, blk, slot;
    logic [IDX_W-1:0] cnt_ix;
    logic first;
    ctl_word_t w;
    w = '0;
    rel  = 32'(s) - 2;
    blk  = rel / 7;
    slot = rel % 7;
    cnt_ix = IDX_W'(blk);
    first = (blk == 0);
    if (s == 0)       w = mk(1'b0, 1'b0, 1'b0, 1'b1, IX_TAG_INIT);
    else if (s == 1)  w = mk(1'b0, 1'b0, 1'b0, 1'b0, IX_SETTLE);
    else if (s >= 30) w = mk(1'b0, 1'b0, 1'b1, 1'b1, IX_TAG_RST);
    else if (rd) begin
      case (slot)
        0: w = mk(1'b0, 1'b0, 1'b0, 1'b0, first ? IX_RWAIT_1ST : IX_RWAIT_NXT);
        1: w = mk(1'b0, 1'b0, 1'b0, 1'b1, IX_TAG_RD);
        2: w = mk(1'b1, 1'b1, 1'b0, 1'b0, cnt_ix);
        3: w = mk(1'b1, 1'b1, 1'b0, 1'b0, IX_SETTLE);
        4: w = mk(1'b1, 1'b0, 1'b0, 1'b1, IX_TAG_INIT);
        5: w = mk(1'b1, 1'b0, 1'b0, 1'b0, IX_MIN);
        default: w = mk(1'b0, 1'b0, 1'b1, 1'b0, IX_MIN);
      endcase
    end else begin
      case (slot)
        0: w = mk(1'b0, 1'b0, 1'b0, 1'b1, IX_TAG_WR);
        1: w = mk(1'b0, 1'b0, 1'b0, 1'b0, first ? IX_WPRE_1ST : IX_WPRE_NXT);
        2: w = mk(1'b1, 1'b1, 1'b0, 1'b0, IX_MIN);
        3: w = mk(1'b1, 1'b1, 1'b0, 1'b0, cnt_ix);
        4: w = mk(1'b0, 1'b1, 1'b0, 1'b0, IX_MIN);
        5: w = mk(1'b0, 1'b0, 1'b0, 1'b0, IX_ECC_P1);
        default: w = mk(1'b0, 1'b0, 1'b1, 1'b0, IX_MIN);
      endcase
    end
    return w;
  endfunction

  // Remaining-count arithmetic used by the step timer.
  function automatic logic [31:0] count_next(logic [31:0] remaining);
    return (remaining == 0) ? 32'd0 : remaining - 32'd1;
  endfunction

endpackage

// File: rtl/sectseq_prog_rom.sv
module sectseq_prog_rom
  import sectseq_pkg::*;
(
  input  logic              rd,
  input  logic [STEP_W-1:0] step,
  output ctl_word_t         word
);
  ctl_word_t prog_out [2];

  for (genvar p = 0; p < 2; p++) begin : g_prog
    assign prog_out[p] = prog_word(p[0], step);
  end

  assign word = rd ? prog_out[1] : prog_out[0];
endmodule

// File: rtl/sectseq_param_ram.sv
module sectseq_param_ram
  import sectseq_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int DEPTH = PRM_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] mem_rd [16];

  for (genvar e = 0; e < 16; e++) begin : g_ent
    if (e < DEPTH) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n)                                    mem_q[e] <= '0;
        else if (wr_en && wr_addr == IDX_W'(e))        mem_q[e] <= wr_data;
      end
      assign mem_rd[e] = mem_q[e];
    end else begin : g_none
      assign mem_rd[e] = '0;
    end
  end

  assign rd_data = mem_rd[rd_addr];
endmodule

// File: rtl/sectseq_step_timer.sv
module sectseq_step_timer
  import sectseq_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             entry,
  input  logic             tag_mode,
  input  logic             sync_mode,
  input  logic             sync_det,
  input  logic [WIDTH-1:0] load_val,
  output logic             done
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] remaining;
  logic             counting;

  assign remaining = entry ? load_val : cnt_q;
  assign counting  = active && !tag_mode && !sync_mode;

  always_comb begin
    if (!active)        done = 1'b0;
    else if (sync_mode) done = sync_det;
    else if (tag_mode)  done = 1'b1;
    else                done = (remaining == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (counting && !done) cnt_q <= WIDTH'(count_next(32'(remaining)));
  end
endmodule

// File: rtl/sector_sequencer.sv
module sector_sequencer
  import sectseq_pkg::*;
#(
  parameter int PRM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_sel,
  input  logic             sync_det,
  input  logic             prm_we,
  input  logic [3:0]       prm_addr,
  input  logic [PRM_W-1:0] prm_wdata,
  output logic             busy,
  output logic [4:0]       step,
  output logic             tag_load,
  output logic [PRM_W-1:0] tag_value,
  output logic             sr_load,
  output logic             sr_read,
  output logic             ecc_en,
  output logic             new_block
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              entry_q;
  logic              rd_prog;
  ctl_word_t         cw;
  logic [PRM_W-1:0]  prm_val;

  // Named internal events
  logic step_entry, step_adv, timer_done, sync_wait, prm_wr_ok, launch;

  assign step_entry = busy_q && entry_q;
  assign sync_wait  = cw.tag && (cw.idx == IX_TAG_RD);
  assign step_adv   = busy_q && timer_done;
  assign prm_wr_ok  = prm_we && !busy_q;
  assign launch     = start && !busy_q;

  sectseq_prog_rom u_rom (
    .rd   (rd_prog),
    .step (step_q),
    .word (cw)
  );

  sectseq_param_ram #(.WIDTH(PRM_W), .DEPTH(PRM_N)) u_prm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prm_wr_ok),
    .wr_addr (prm_addr),
    .wr_data (prm_wdata),
    .rd_addr (cw.idx),
    .rd_data (prm_val)
  );

  sectseq_step_timer #(.WIDTH(PRM_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (busy_q),
    .entry     (entry_q),
    .tag_mode  (cw.tag && !sync_wait),
    .sync_mode (sync_wait),
    .sync_det  (sync_det),
    .load_val  (prm_val),
    .done      (timer_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      entry_q <= 1'b0;
      rd_prog <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      step_q  <= '0;
      entry_q <= 1'b1;
      rd_prog <= rd_sel;
    end else if (step_adv) begin
      entry_q <= 1'b1;
      if (cw.nblk) rd_prog <= rd_sel;
      if (step_q == LAST_STEP) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else begin
      entry_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign step      = step_q;
  assign tag_load  = step_entry && cw.tag;
  assign tag_value = tag_load ? prm_val : '0;
  assign sr_load   = busy_q && cw.ser && !rd_prog;
  assign sr_read   = busy_q && cw.ser && rd_prog;
  assign ecc_en    = busy_q && cw.ecc;
  assign new_block = busy_q && cw.nblk;
endmodule

// File: rtl/sectseq_chk.sv
module sectseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sync_det,
  input logic       busy,
  input logic [4:0] step,
  input logic       step_adv,
  input logic       step_entry,
  input logic       sync_wait,
  input logic       rd_prog,
  input logic       new_block,
  input logic       tag_load,
  input logic       sr_load,
  input logic       sr_read,
  input logic       prm_wr_ok
);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && step == 5'd0));

  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && step != 5'd31) |=> (busy && step == $past(step) + 5'd1));

  assert_tag_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tag_load |-> (busy && step_entry));

  assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sync_wait && !sync_det) |=> (busy && $stable(step)));

  assert_sel_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(step_adv && new_block)) |=> $stable(rd_prog));

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && step == 5'd31) |=> !busy);

  assert_no_write_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prm_wr_ok);

  assert_ser_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_load && sr_read));
endmodule

bind sector_sequencer sectseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .sync_det   (sync_det),
  .busy       (busy),
  .step       (step),
  .step_adv   (step_adv),
  .step_entry (step_entry),
  .sync_wait  (sync_wait),
  .rd_prog    (rd_prog),
  .new_block  (new_block),
  .tag_load   (tag_load),
  .sr_load    (sr_load),
  .sr_read    (sr_read),
  .prm_wr_ok  (prm_wr_ok)
);

// File: tb/sim_sector_sequencer.sv
module sim_sector_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, rd_sel = 1'b0, sync_det = 1'b0, prm_we = 1'b0;
  logic [3:0]    prm_addr = '0;
  logic [PW-1:0] prm_wdata = '0;
  logic          busy, tag_load, sr_load, sr_read, ecc_en, new_block;
  logic [4:0]    step;
  logic [PW-1:0] tag_value;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic [PW-1:0] shadow [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_sequencer #(.PRM_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel), .sync_det(sync_det),
    .prm_we(prm_we), .prm_addr(prm_addr), .prm_wdata(prm_wdata),
    .busy(busy), .step(step), .tag_load(tag_load), .tag_value(tag_value),
    .sr_load(sr_load), .sr_read(sr_read), .ecc_en(ecc_en), .new_block(new_block));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Expected control word: bit7 ser, bit6 ecc, bit5 new-block, bit4 tag, 3:0 index (R3, R7, R8, R9)
  function automatic logic [7:0] exp_word(bit rd, int s);
    logic [7:0] rsl [7];
    logic [7:0] wsl [7];
    int b, k;
    if (s == 0) return 8'h16;
    if (s == 1) return 8'h0D;
    if (s >= 30) return 8'h37;
    b = (s - 2) / 7;
    k = (s - 2) - 7 * b;
    rsl = '{(b == 0) ? 8'h0A : 8'h0B, 8'h14, 8'hC0 | 8'(b), 8'hCD, 8'h96, 8'h8E, 8'h2E};
    wsl = '{8'h15, (b == 0) ? 8'h08 : 8'h09, 8'hCE, 8'hC0 | 8'(b), 8'h4E, 8'h0C, 8'h2E};
    return rd ? rsl[k] : wsl[k];
  endfunction

  task automatic chk_idle(string req);
    chk({req, " busy"}, 32'(busy), 0);
    chk({req, " step"}, 32'(step), 0);
    chk({req, " outs"}, {26'd0, tag_load, sr_load, sr_read, ecc_en, new_block, 1'b0}, 0);
    chk({req, " tagv"}, 32'(tag_value), 0);
  endtask

  task automatic idle_write(logic [3:0] a, logic [PW-1:0] d);
    prm_we = 1'b1; prm_addr = a; prm_wdata = d;
    @(negedge clk);
    prm_we = 1'b0;
    if (a != 4'd15) shadow[a] = d;
  endtask

  // Runs one sector program; caller is at a negedge with the block idle.
  task automatic run_seq(bit rd0, bit rd_rand, int sync_max, bit junk);
    bit rd_cur, rd_nxt;
    start = 1'b1; rd_sel = rd0;
    @(negedge clk);
    start = 1'b0;
    rd_cur = rd0;
    for (int s = 0; s < 32; s++) begin
      logic [7:0] w;
      bit is_tag, is_rdtag;
      int dur;
      w = exp_word(rd_cur, s);
      is_tag = w[4];
      is_rdtag = is_tag && (w[3:0] == 4'd4);
      rd_nxt = rd_cur;
      if (is_rdtag) dur = (sync_max == 0) ? 1 : int'($urandom % sync_max) + 1;
      else if (is_tag) dur = 1;
      else dur = int'(shadow[w[3:0]]) + 1;
      for (int c = 0; c < dur; c++) begin
        sync_det = is_rdtag && (c == dur - 1);
        chk("R2 busy", 32'(busy), 1);
        chk(is_rdtag ? "R6 step" : "R4 step", 32'(step), 32'(s));
        chk("R5 tag_load", 32'(tag_load), 32'(is_tag && c == 0));
        chk("R5 tag_value", 32'(tag_value),
            (is_tag && c == 0) ? 32'(shadow[w[3:0]]) : 0);
        chk(rd_cur ? "R7 flags" : "R8 flags", {28'd0, ecc_en, new_block, 2'b00},
            {28'd0, w[6], w[5], 2'b00});
        chk("R13 ser", {30'd0, sr_load, sr_read}, {30'd0, w[7] && !rd_cur, w[7] && rd_cur});
        if (junk) begin
          start = 1'($urandom);
          prm_we = 1'($urandom);
          prm_addr = 4'($urandom);
          prm_wdata = PW'($urandom);
        end
        if (rd_rand) rd_sel = 1'($urandom);
        if (c == dur - 1 && w[5]) rd_nxt = rd_sel;
        @(negedge clk);
      end
      sync_det = 1'b0;
      rd_cur = rd_nxt;
    end
    start = 1'b0; prm_we = 1'b0;
    chk_idle("R11");
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    // R12: address 15 dropped (no visible effect expected), real writes kept
    idle_write(4'd15, 12'hABC);
    for (int a = 0; a < 15; a++) idle_write(4'(a), PW'(a % 4));
    for (int a = 4; a < 8; a++) idle_write(4'(a), PW'(12'h100 + a));
    // Directed: read then write, fixed select, immediate sync
    run_seq(1'b1, 1'b0, 0, 1'b0);
    run_seq(1'b0, 1'b0, 3, 1'b0);
    // Directed: all lengths zero
    for (int a = 0; a < 15; a++) if (a < 4 || a > 7) idle_write(4'(a), '0);
    run_seq(1'b0, 1'b0, 1, 1'b0);
    run_seq(1'b1, 1'b0, 1, 1'b0);
    // Directed: long count on block 0
    idle_write(4'd0, 12'd600);
    run_seq(1'b1, 1'b0, 2, 1'b0);
    // Random: parameters, select toggling (R10), busy writes/starts ignored (R2, R12)
    for (int r = 0; r < 14; r++) begin
      for (int a = 0; a < 15; a++)
        idle_write(4'(a), (a >= 4 && a <= 7) ? PW'($urandom) : PW'($urandom % 6));
      run_seq(1'($urandom), 1'b1, 5, 1'b1);
    end
    chk_idle("R11");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule